// File: doc/BRIEF.md
# Interleaved PCM Bus Multiplexer

This block is one participant on a shared serial PCM bus that carries the 2.048 Mbit/s E1 frames of two or four framers. Each participant reads its own frame, one byte-wide timeslot at a time, from its elastic store. It places those bytes on the bus only in the bit positions that belong to it, and it asserts a tri-state enable for exactly those positions. The bus clock is the block clock: 4.096 MHz when two sources share the bus and 8.192 MHz when four do. A 125 µs bus frame therefore holds 512 or 1024 bit positions.

A small configuration register selects the participant's behaviour. It holds an enable, a choice between byte and frame interleaving, and a role code that makes the participant the bus master for two or four sources, or a slave. The master always occupies source position 0, counts bit positions itself and issues a one-clock frame sync on the first bit of each bus frame. A slave takes its source position and the bus size from strapped pins. It realigns its position counter to the incoming sync and drives nothing until it has seen one.

Top module: `pcm_ilv_bus`

## Requirements
- R1: After reset, the configuration reads as 0 and `bus_oe`, `bus_dout` and `fs_out` are 0.
- R2: A write stores `cfg_wdata[3:0]` (bit 3 enable, bit 2 frame interleave when 1, bits 1 and 0 the role code). The role code's high bit is held in bit 0 and its low bit in bit 1. Bits 7:4 always read 0.
- R3: With role code 01 (register value 0x0A), the participant is master of a 512-position frame, whatever `bus_quad` says. `fs_out` is high for exactly one clock, on position 0 of every frame.
- R4: With role code 10 (register value 0x09), the participant is master of a 1024-position frame, whatever `bus_quad` says. `fs_out` behaves as in R3.
- R5: In byte interleave, bus byte b carries timeslot b/N of source b mod N, where N is 2 or 4.
- R6: In frame interleave, bus byte b carries timeslot b mod 32 of source b/32.
- R7: Within a bus byte, the timeslot's bits go out MSB first. `es_slot` names the timeslot whose byte is read from `es_data`, and `bus_oe` is 1 for exactly the positions the participant drives.
- R8: A slave (role code 00) never asserts `fs_out`. After `fs_in` is sampled high, the next clock presents bus position 1, so the slave's counter restarts even in the middle of one of its own bytes. The slave then free-runs and wraps at the frame length chosen by `bus_quad` (0: 512, 1: 1024).
- R9: A slave drives nothing before its first `fs_in`. It also drives nothing when `bus_pos` is 0 or is not below N.
- R10: While the enable bit is 0, `bus_oe` and `fs_out` stay 0 from the second clock after the write onward.
- R11: Role code 11 (register value 0x0B) behaves as a slave with its bus output disabled: neither `bus_oe` nor `fs_out` is ever asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| bus_pos | input | 2 | Strapped source position (used when slave) |
| bus_quad | input | 1 | Strapped bus size for a slave: 1 for four sources |
| fs_in | input | 1 | Bus frame sync from the master |
| fs_out | output | 1 | Bus frame sync generated by the master |
| es_slot | output | 5 | Timeslot address into the elastic store |
| es_data | input | 8 | Timeslot byte read from the elastic store |
| bus_dout | output | 1 | Serial bus data |
| bus_oe | output | 1 | Tri-state enable for `bus_dout` |

## Verification
A slave's realignment to an incoming sync can land in the same clock as the serialisation of one of its own bytes. In that clock the counter jump and the shift register's bit-by-bit progress compete. The bench provokes this by locking a slave at position 1 of a two-source byte-interleaved bus, stepping it to bit 2 of its first own byte, and pulsing `fs_in` there. It judges the result by requiring `bus_oe` to fall on the very next clock, which then presents position 1. It also requires that every later position of the frame, including the slave's next fresh byte load at position 8, matches the independently computed bus order.

// File: rtl/pcm_ilv_pkg.sv
package pcm_ilv_pkg;

    localparam int SLOTS_PER_FRAME = 32;
    localparam int BITS_PER_SLOT   = 8;
    localparam int MAX_SOURCES     = 4;
    localparam int SMALL_SOURCES   = MAX_SOURCES / 2;
    localparam int REG_W           = 8;
    localparam int CFG_W           = 4;

    localparam int SLOT_W  = $clog2(SLOTS_PER_FRAME);
    localparam int BIT_W   = $clog2(BITS_PER_SLOT);
    localparam int SRC_W   = $clog2(MAX_SOURCES);
    localparam int SMALL_W = $clog2(SMALL_SOURCES);
    localparam int CNT_W   = $clog2(MAX_SOURCES * SLOTS_PER_FRAME * BITS_PER_SLOT);
    localparam int BYTE_W  = CNT_W - BIT_W;

    localparam int FRAME_SMALL = SMALL_SOURCES * SLOTS_PER_FRAME * BITS_PER_SLOT;
    localparam int FRAME_LARGE = MAX_SOURCES * SLOTS_PER_FRAME * BITS_PER_SLOT;

    typedef enum logic [1:0] {
        ROLE_SLAVE     = 2'b00,
        ROLE_MASTER_X2 = 2'b01,
        ROLE_MASTER_X4 = 2'b10,
        ROLE_RESERVED  = 2'b11
    } role_e;

    typedef struct packed {
        logic  enable;
        logic  frame_mode;
        role_e role;
    } bus_cfg_t;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } bus_place_t;

    // Role code high bit sits in register bit 0, low bit in register bit 1.
    function automatic bus_cfg_t cfg_decode(input logic [CFG_W-1:0] raw);
        bus_cfg_t c;
        c.enable     = raw[3];
        c.frame_mode = raw[2];
        c.role       = role_e'({raw[0], raw[1]});
        return c;
    endfunction

    function automatic logic role_is_master(input role_e r);
        return (r == ROLE_MASTER_X2) || (r == ROLE_MASTER_X4);
    endfunction

endpackage

// File: rtl/pcm_ilv_cfg.sv
module pcm_ilv_cfg
    import pcm_ilv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output bus_cfg_t         cfg
);

    logic [CFG_W-1:0] raw_q;
    logic             unused_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else if (wr) begin
            raw_q <= wdata[CFG_W-1:0];
        end
    end

    assign unused_hi = ^wdata[REG_W-1:CFG_W];
    assign rdata     = {{(REG_W-CFG_W){1'b0}}, raw_q};
    assign cfg       = cfg_decode(raw_q);

endmodule

// File: rtl/pcm_ilv_timer.sv
module pcm_ilv_timer
    import pcm_ilv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_cfg_t         cfg,
    input  logic             quad_pin,
    input  logic             fs_in,
    output logic [CNT_W-1:0] pos_nxt,
    output logic             quad,
    output logic             aligned,
    output logic             fs_out
);

    localparam logic [CNT_W-1:0] LAST_SMALL = CNT_W'(FRAME_SMALL - 1);
    localparam logic [CNT_W-1:0] LAST_LARGE = CNT_W'(FRAME_LARGE - 1);
    localparam logic [CNT_W-1:0] AFTER_SYNC = CNT_W'(1);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] last;
    logic             master;
    logic             resync;
    logic             locked_q;

    assign master = role_is_master(cfg.role);

    always_comb begin
        unique case (cfg.role)
            ROLE_MASTER_X4: quad = 1'b1;
            ROLE_MASTER_X2: quad = 1'b0;
            default:        quad = quad_pin;
        endcase
    end

    assign last   = quad ? LAST_LARGE : LAST_SMALL;
    assign resync = !master && fs_in;

    always_comb begin
        if (resync) begin
            pos_nxt = AFTER_SYNC;
        end else if (pos_q >= last) begin
            pos_nxt = '0;
        end else begin
            pos_nxt = pos_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            locked_q <= 1'b0;
            fs_out   <= 1'b0;
        end else begin
            pos_q    <= pos_nxt;
            fs_out   <= cfg.enable && master && (pos_nxt == '0);
            locked_q <= cfg.enable && (cfg.role == ROLE_SLAVE) && (locked_q || fs_in);
        end
    end

    assign aligned = master || locked_q || resync;

endmodule

// File: rtl/pcm_ilv_order.sv
module pcm_ilv_order
    import pcm_ilv_pkg::*;
(
    input  logic [CNT_W-1:0] pos,
    input  logic             quad,
    input  logic             frame_mode,
    output bus_place_t       place
);

    logic [BYTE_W-1:0] byte_idx;

    assign byte_idx = pos[CNT_W-1:BIT_W];

    always_comb begin
        place.bitn = pos[BIT_W-1:0];
        if (frame_mode) begin
            place.src  = byte_idx[SLOT_W +: SRC_W];
            place.slot = byte_idx[SLOT_W-1:0];
        end else if (quad) begin
            place.src  = byte_idx[SRC_W-1:0];
            place.slot = byte_idx[SRC_W +: SLOT_W];
        end else begin
            place.src  = SRC_W'(byte_idx[SMALL_W-1:0]);
            place.slot = byte_idx[SMALL_W +: SLOT_W];
        end
    end

endmodule

// File: rtl/pcm_ilv_ser.sv
module pcm_ilv_ser
    import pcm_ilv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     drive,
    input  logic [BIT_W-1:0]         bitn,
    input  logic [BITS_PER_SLOT-1:0] es_data,
    output logic                     dout,
    output logic                     oe
);

    logic [BITS_PER_SLOT-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            dout    <= 1'b0;
            oe      <= 1'b0;
        end else begin
            oe <= drive;
            if (!drive) begin
                dout <= 1'b0;
            end else if (bitn == '0) begin
                dout    <= es_data[BITS_PER_SLOT-1];
                shift_q <= {es_data[BITS_PER_SLOT-2:0], 1'b0};
            end else begin
                dout    <= shift_q[BITS_PER_SLOT-1];
                shift_q <= {shift_q[BITS_PER_SLOT-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/pcm_ilv_bus.sv
module pcm_ilv_bus
    import pcm_ilv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic [REG_W-1:0]         cfg_rdata,
    input  logic [SRC_W-1:0]         bus_pos,
    input  logic                     bus_quad,
    input  logic                     fs_in,
    output logic                     fs_out,
    output logic [SLOT_W-1:0]        es_slot,
    input  logic [BITS_PER_SLOT-1:0] es_data,
    output logic                     bus_dout,
    output logic                     bus_oe
);

    bus_cfg_t         cfg;
    logic [CNT_W-1:0] pos_nxt;
    logic             quad;
    logic             aligned;
    bus_place_t       place;
    logic             master;
    logic [SRC_W-1:0] my_src;
    logic             pos_ok;
    logic             drive;

    pcm_ilv_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    pcm_ilv_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .quad_pin (bus_quad),
        .fs_in    (fs_in),
        .pos_nxt  (pos_nxt),
        .quad     (quad),
        .aligned  (aligned),
        .fs_out   (fs_out)
    );

    pcm_ilv_order u_order (
        .pos        (pos_nxt),
        .quad       (quad),
        .frame_mode (cfg.frame_mode),
        .place      (place)
    );

    assign master = role_is_master(cfg.role);
    assign my_src = master ? '0 : bus_pos;

    always_comb begin
        if (master) begin
            pos_ok = 1'b1;
        end else if (quad) begin
            pos_ok = (bus_pos != '0);
        end else begin
            pos_ok = (bus_pos != '0) && (int'(bus_pos) < SMALL_SOURCES);
        end
    end

    assign drive = cfg.enable && (cfg.role != ROLE_RESERVED) && aligned
                   && pos_ok && (place.src == my_src);

    assign es_slot = place.slot;

    pcm_ilv_ser u_ser (
        .clk     (clk),
        .rst     (rst),
        .drive   (drive),
        .bitn    (place.bitn),
        .es_data (es_data),
        .dout    (bus_dout),
        .oe      (bus_oe)
    );

endmodule

// File: rtl/pcm_ilv_bus_chk.sv
module pcm_ilv_bus_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_rdata,
    input logic       fs_out,
    input logic       bus_oe,
    input logic       bus_dout
);

    logic mst_now;
    logic rsv_now;

    assign mst_now = cfg_rdata[3] && (cfg_rdata[1] ^ cfg_rdata[0]);
    assign rsv_now = cfg_rdata[1] && cfg_rdata[0];

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!bus_oe && !bus_dout && !fs_out && cfg_rdata == 8'h00));

    // R2
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:4] == 4'h0);

    // R3
    a_r3_sync_single: assert property (@(posedge clk) disable iff (rst)
        fs_out |=> !fs_out);

    // R8
    a_r8_slave_no_sync: assert property (@(posedge clk) disable iff (rst)
        (!mst_now && !$past(mst_now)) |-> !fs_out);

    // R10
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[3] && !$past(cfg_rdata[3])) |-> (!bus_oe && !fs_out));

    // R11
    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (rsv_now && $past(rsv_now)) |-> (!bus_oe && !fs_out));

    // R7
    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> !bus_dout);

endmodule

bind pcm_ilv_bus pcm_ilv_bus_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .fs_out    (fs_out),
    .bus_oe    (bus_oe),
    .bus_dout  (bus_dout)
);

// File: tb/pcm_ilv_bus_test.sv
module pcm_ilv_bus_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [1:0] bus_pos = 2'd0;
    logic       bus_quad = 1'b0;
    logic       fs_in = 1'b0;
    logic       fs_out;
    logic [4:0] es_slot;
    logic [7:0] es_data;
    logic       bus_dout;
    logic       bus_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pcm_ilv_bus uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bus_pos   (bus_pos),
        .bus_quad  (bus_quad),
        .fs_in     (fs_in),
        .fs_out    (fs_out),
        .es_slot   (es_slot),
        .es_data   (es_data),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe)
    );

    function automatic logic [7:0] es_val(input logic [4:0] s);
        return 8'((int'(s) * 37 + 90) & 255);
    endfunction

    assign es_data = es_val(es_slot);

    // {cfg[3:0], bus_pos[1:0], quad, is_master}
    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{
        8'hA1, 8'hE1, 8'h93, 8'hD3, 8'h84, 8'hCE, 8'h8A, 8'hC4
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = 1'b0; fs_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // expected {oe, dout} at bus position p
    function automatic logic [1:0] exp_at(input int p, input bit quad, input bit frm, input int me);
        int n;
        int b;
        int src;
        int slot;
        logic [7:0] v;
        n = quad ? 4 : 2;
        b = p / 8;
        if (frm) begin src = b / 32; slot = b % 32; end
        else     begin src = b % n;  slot = b / n;  end
        if (src != me) return 2'b00;
        v = es_val(5'(slot));
        return {1'b1, v[7 - (p % 8)]};
    endfunction

    // Called at a negedge showing position 'first'; ends showing the next frame's position 0.
    task automatic check_frame(input int first, input bit quad, input bit frm, input int me,
                               input bit want_fs, input string tag);
        int len;
        int bad;
        int bad_act;
        int bad_exp;
        logic [1:0] e;
        len = quad ? 1024 : 512;
        bad = 0; bad_act = 0; bad_exp = 0;
        for (int p = first; p < len; p++) begin
            e = exp_at(p, quad, frm, me);
            if (bus_oe !== e[1] || (e[1] && bus_dout !== e[0]) || fs_out !== (want_fs && p == first && first == 0)) begin
                if (bad == 0) begin
                    bad_act = {p, 1'b0, fs_out, bus_oe, bus_dout};
                    bad_exp = {p, 1'b0, (want_fs && p == 0), e};
                end
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, tag, bad_act, bad_exp);
    endtask

    task automatic watch_quiet(input int cycles, input bit pulse_fs, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            fs_in = pulse_fs && (i % 300 == 5);
            if (bus_oe !== 1'b0 || fs_out !== 1'b0) seen++;
            @(negedge clk);
        end
        fs_in = 1'b0;
        check(seen == 0, tag, seen, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1 reset state
        check(cfg_rdata == 8'h00 && bus_oe == 1'b0 && bus_dout == 1'b0 && fs_out == 1'b0,
              "R1 reset state", {cfg_rdata, fs_out, bus_oe, bus_dout}, 0);

        // R2 register width
        write_cfg(8'hF2);
        check(cfg_rdata == 8'h02, "R2 upper bits read 0", cfg_rdata, 8'h02);
        write_cfg(8'hA5);
        check(cfg_rdata == 8'h05, "R2 low nibble stored", cfg_rdata, 8'h05);

        // table of configurations
        for (int k = 0; k < NVEC; k++) begin
            logic [3:0] c;
            logic [1:0] ps;
            bit q;
            bit m;
            bit frm;
            int w;
            {c, ps, q, m} = VEC[k];
            frm = c[2];
            do_reset();
            bus_pos  = ps;
            bus_quad = m ? !q : q;
            write_cfg({4'h0, c});
            if (m) begin
                w = 0;
                while (fs_out !== 1'b1 && w < 1200) begin @(negedge clk); w++; end
                check(fs_out === 1'b1, q ? "R4 master sync seen" : "R3 master sync seen", fs_out, 1);
                check_frame(0, q, frm, 0, 1'b1,
                            frm ? "R6 R7 master frame order" : "R5 R7 master byte order");
                check(fs_out === 1'b1, q ? "R4 frame length 1024" : "R3 frame length 512", fs_out, 1);
            end else begin
                watch_quiet(600, 1'b0, "R9 slave quiet before sync");
                fs_in = 1'b1;
                @(negedge clk);
                fs_in = 1'b0;
                check_frame(1, q, frm, int'(ps), 1'b0,
                            frm ? "R6 R8 slave frame order" : "R5 R8 slave byte order");
                check_frame(0, q, frm, int'(ps), 1'b0, "R8 slave wrap at bus_quad length");
            end
        end

        // R8 corner: resync lands inside the slave's own byte
        do_reset();
        bus_pos = 2'd1; bus_quad = 1'b0;
        write_cfg(8'h08);
        fs_in = 1'b1;
        @(negedge clk);
        fs_in = 1'b0;
        repeat (9) @(negedge clk);
        check(bus_oe === 1'b1, "R8 slave driving own byte at position 10", bus_oe, 1);
        fs_in = 1'b1;
        @(negedge clk);
        fs_in = 1'b0;
        check(bus_oe === 1'b0, "R8 resync drops drive next clock", bus_oe, 0);
        check_frame(1, 1'b0, 1'b0, 1, 1'b0, "R8 R7 order after mid-byte resync");

        // R9 slave at position 0 never drives
        do_reset();
        bus_pos = 2'd0; bus_quad = 1'b0;
        write_cfg(8'h08);
        watch_quiet(1100, 1'b1, "R9 slave at position 0 silent");

        // R9 slave position outside a two-source bus
        do_reset();
        bus_pos = 2'd3; bus_quad = 1'b0;
        write_cfg(8'h08);
        watch_quiet(1100, 1'b1, "R9 slave position beyond N silent");

        // R11 reserved role
        do_reset();
        bus_pos = 2'd1; bus_quad = 1'b0;
        write_cfg(8'h0B);
        watch_quiet(1100, 1'b1, "R11 reserved role silent");

        // R10 disabled master
        do_reset();
        write_cfg(8'h02);
        watch_quiet(1100, 1'b0, "R10 disabled master silent");

        // R10 disable while running
        do_reset();
        write_cfg(8'h0A);
        repeat (300) @(negedge clk);
        write_cfg(8'h02);
        @(negedge clk);
        watch_quiet(1100, 1'b0, "R10 disable mid-frame");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule